// File: doc/BRIEF.md
# Fault-Aware Systolic Weight Placement Unit

This block turns a stream of logical weight indices (i, j) into physical placement addresses on an N-by-N systolic multiply array whose faulty rows and columns are known. Software or a configuration sequencer first loads a row fault mask, a column fault mask and a fault-count threshold. It then starts a matrix by giving its dimensions. The block counts the faulty lines, picks a placement policy and holds that policy until every weight of the matrix has been accepted. Each accepted weight produces an array row `out_x` and an array column `out_y`, a flag saying whether the matrix was transposed, and a flag marking weights that land on a faulty processing element and must be dropped.

There are three policies. Direct placement puts the weight at row i mod N and column j mod N. Transposed placement swaps the roles of i and j. That way a small number of faulty columns only removes input-side contributions, in the same way that a small number of faulty rows does. Reduction is used when the faults in a dimension exceed the threshold. It removes every faulty line of that dimension and maps the logical index, taken modulo the count of healthy lines, onto the k-th healthy physical line. A lookup table built when the masks are loaded gives that line directly. If every row or every column is faulty, the block cannot place anything and signals an error.

The controller has three states. IDLE accepts `load` and `start`. RUN accepts weights. FAULT holds the error. The transitions are: IDLE to RUN (start with a usable array), IDLE to FAULT (start with all rows or all columns faulty), RUN to IDLE (last weight of the matrix accepted), and FAULT to IDLE (load). A load in IDLE stays in IDLE and takes priority over a start in the same cycle.

Top module: `wm_weight_mapper`

## Requirements
- R1: After reset, `out_valid`, `busy` and `err` are 0, both fault masks are clear and the threshold is 0.
- R2: With no faulty column and at most `threshold` faulty rows, a weight is placed at x = i mod N and y = j mod N, with `out_transpose` = 0.
- R3: `out_skip` is 1 exactly when the row mask bit at position `out_x` or the column mask bit at position `out_y` is 1. Mask bit p stands for physical line p.
- R4: When the number of faulty rows exceeds `threshold`, rows are reduced. The row index is a mod H, where a is the row-side logical index and H is the count of healthy rows. `out_x` is the healthy row of that rank, counting healthy rows from bit 0 upward. It is never a faulty row.
- R5: When the number of faulty columns exceeds `threshold`, columns are reduced in the same way. `out_y` is the healthy column whose rank is b mod (count of healthy columns). It is never a faulty column.
- R6: When at least one column is faulty, neither dimension exceeds `threshold`, and transposition applies, `out_transpose` = 1. The row-side index a becomes j and the column-side index b becomes i. In every other case a = i and b = j.
- R7: A count equal to `threshold` is treated as low and a count one above it as high. Each dimension is compared on its own.
- R8: A start when all N rows or all N columns are faulty enters FAULT. There `err` = 1, `busy` = 0 and weights produce no output. A load returns the block to IDLE and clears `err`.
- R9: A weight presented with `in_valid` in RUN appears on the outputs one cycle later, with `out_valid`, `out_x`, `out_y`, `out_skip` and `out_transpose` all updated together.
- R10: The policy, masks and matrix size are taken at start. During RUN, `load` and `start` are ignored.
- R11: RUN ends after exactly `dim_i`*`dim_j` weights have been accepted (both dimensions at least 1). Outside RUN, `in_valid` produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture fault masks and threshold (IDLE or FAULT only) |
| row_fault | input | N | Faulty-row mask, bit p = physical row p |
| col_fault | input | N | Faulty-column mask, bit p = physical column p |
| threshold | input | $clog2(N+1) | Highest fault count still treated as low |
| start | input | 1 | Begin a matrix; latches policy and size |
| dim_i | input | IDX_W | Matrix extent in i (at least 1) |
| dim_j | input | IDX_W | Matrix extent in j (at least 1) |
| in_valid | input | 1 | A weight index is presented |
| in_i | input | IDX_W | Logical index i |
| in_j | input | IDX_W | Logical index j |
| busy | output | 1 | State is RUN |
| err | output | 1 | State is FAULT |
| out_valid | output | 1 | Placement outputs are valid |
| out_x | output | $clog2(N) | Physical array row |
| out_y | output | $clog2(N) | Physical array column |
| out_skip | output | 1 | Target element is faulty; drop the weight |
| out_transpose | output | 1 | Matrix is placed transposed |

## Verification
The bench builds the block with N = 4 and IDX_W = 4. At that size all 256 pairs of row and column masks can be swept at thresholds 0, 1 and 2. The sweep covers every policy, every threshold boundary, every all-faulty error case and every healthy-line rank in the reduction tables. A 6-by-5 matrix makes both indices wrap past N, and under reduction they also wrap past every possible healthy count. Directed runs add loads and starts issued during RUN, weights presented outside RUN, and recovery from FAULT.

// File: rtl/wm_pkg.sv
package wm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } wm_state_e;

    typedef struct packed {
        logic row_red;
        logic col_red;
        logic swap;
    } wm_policy_t;

endpackage

// File: rtl/wm_line_table.sv
module wm_line_table #(
    parameter int N  = 8,
    parameter int CW = 4,
    parameter int IW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [N-1:0]            mask_in,
    output logic [N-1:0]            mask_q,
    output logic [CW-1:0]           bad_q,
    output logic [CW-1:0]           good_q,
    output logic [N-1:0][IW-1:0]    lut_q
);

    logic [N-1:0][IW-1:0] lut_n;
    logic [CW-1:0]        rank;

    // Priority scan: the k-th clear bit from position 0 becomes entry k.
    always_comb begin
        lut_n = '0;
        rank  = '0;
        for (int p = 0; p < N; p++) begin
            if (!mask_in[p]) begin
                lut_n[rank[IW-1:0]] = IW'(p);
                rank = rank + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            bad_q  <= '0;
            good_q <= CW'(N);
            for (int p = 0; p < N; p++) begin
                lut_q[p] <= IW'(p);
            end
        end else if (load) begin
            mask_q <= mask_in;
            bad_q  <= CW'(N) - rank;
            good_q <= rank;
            lut_q  <= lut_n;
        end
    end

    generate
        for (genvar e = 0; e < N; e++) begin : g_chk
            a_r4_lut_healthy: assert property (@(posedge clk) disable iff (!rst_n)
                (good_q > CW'(e)) |-> !mask_q[lut_q[e]]);
        end
    endgenerate

endmodule

// File: rtl/wm_policy_sel.sv
module wm_policy_sel
    import wm_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [CW-1:0] row_bad,
    input  logic [CW-1:0] col_bad,
    input  logic [CW-1:0] thr,
    output wm_policy_t    pol,
    output logic          all_bad
);

    always_comb begin
        pol.row_red = (row_bad > thr);
        pol.col_red = (col_bad > thr);
        // Column faults are steered onto the input side when both counts are low.
        pol.swap    = (col_bad != '0) && !pol.row_red && !pol.col_red;
        all_bad     = (row_bad == CW'(N)) || (col_bad == CW'(N));
    end

endmodule

// File: rtl/wm_addr_gen.sv
module wm_addr_gen
    import wm_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 4,
    parameter int IW = 3,
    parameter int XW = 8
) (
    input  wm_policy_t              pol,
    input  logic [XW-1:0]           idx_i,
    input  logic [XW-1:0]           idx_j,
    input  logic [N-1:0][IW-1:0]    row_lut,
    input  logic [N-1:0][IW-1:0]    col_lut,
    input  logic [CW-1:0]           row_good,
    input  logic [CW-1:0]           col_good,
    input  logic [N-1:0]            row_mask,
    input  logic [N-1:0]            col_mask,
    output logic [IW-1:0]           x,
    output logic [IW-1:0]           y,
    output logic                    skip
);

    logic [XW-1:0] a_idx, b_idx;
    logic [XW-1:0] row_div, col_div;
    logic [XW-1:0] a_red, b_red;

    always_comb begin
        a_idx   = pol.swap ? idx_j : idx_i;
        b_idx   = pol.swap ? idx_i : idx_j;
        row_div = (row_good == '0) ? XW'(1) : XW'(row_good);
        col_div = (col_good == '0) ? XW'(1) : XW'(col_good);
        a_red   = a_idx % row_div;
        b_red   = b_idx % col_div;
        x       = pol.row_red ? row_lut[a_red[IW-1:0]] : IW'(a_idx % XW'(N));
        y       = pol.col_red ? col_lut[b_red[IW-1:0]] : IW'(b_idx % XW'(N));
        skip    = row_mask[x] | col_mask[y];
    end

endmodule

// File: rtl/wm_weight_mapper.sv
module wm_weight_mapper
    import wm_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 8,
    localparam int CW   = $clog2(N + 1),
    localparam int IW   = (N > 1) ? $clog2(N) : 1,
    localparam int TW   = 2 * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N-1:0]     row_fault,
    input  logic [N-1:0]     col_fault,
    input  logic [CW-1:0]    threshold,
    input  logic             start,
    input  logic [IDX_W-1:0] dim_i,
    input  logic [IDX_W-1:0] dim_j,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_i,
    input  logic [IDX_W-1:0] in_j,
    output logic             busy,
    output logic             err,
    output logic             out_valid,
    output logic [IW-1:0]    out_x,
    output logic [IW-1:0]    out_y,
    output logic             out_skip,
    output logic             out_transpose
);

    wm_state_e            state, state_n;
    wm_policy_t           pol_q, pol_c;
    logic                 all_bad;
    logic [CW-1:0]        thr_q;
    logic [TW-1:0]        total_q, issued_q;
    logic                 tab_load, take_start, take_wt, last_wt;

    logic [N-1:0]          row_mask_q, col_mask_q;
    logic [CW-1:0]         row_bad, col_bad, row_good, col_good;
    logic [N-1:0][IW-1:0]  row_lut, col_lut;
    logic [IW-1:0]         x_c, y_c;
    logic                  skip_c;

    assign tab_load   = load && (state != ST_RUN);
    assign take_start = start && !load && (state == ST_IDLE);
    assign take_wt    = in_valid && (state == ST_RUN);
    assign last_wt    = take_wt && (issued_q == total_q - TW'(1));

    wm_line_table #(.N(N), .CW(CW), .IW(IW)) i_rows (
        .clk(clk), .rst_n(rst_n), .load(tab_load), .mask_in(row_fault),
        .mask_q(row_mask_q), .bad_q(row_bad), .good_q(row_good), .lut_q(row_lut)
    );

    wm_line_table #(.N(N), .CW(CW), .IW(IW)) i_cols (
        .clk(clk), .rst_n(rst_n), .load(tab_load), .mask_in(col_fault),
        .mask_q(col_mask_q), .bad_q(col_bad), .good_q(col_good), .lut_q(col_lut)
    );

    wm_policy_sel #(.N(N), .CW(CW)) i_pol (
        .row_bad(row_bad), .col_bad(col_bad), .thr(thr_q),
        .pol(pol_c), .all_bad(all_bad)
    );

    wm_addr_gen #(.N(N), .CW(CW), .IW(IW), .XW(IDX_W)) i_addr (
        .pol(pol_q), .idx_i(in_i), .idx_j(in_j),
        .row_lut(row_lut), .col_lut(col_lut),
        .row_good(row_good), .col_good(col_good),
        .row_mask(row_mask_q), .col_mask(col_mask_q),
        .x(x_c), .y(y_c), .skip(skip_c)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (take_start) begin
                    state_n = all_bad ? ST_FAULT : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last_wt) begin
                    state_n = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (load) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Configuration and job registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q    <= '0;
            pol_q    <= '0;
            total_q  <= '0;
            issued_q <= '0;
        end else begin
            if (tab_load) begin
                thr_q <= threshold;
            end
            if (take_start) begin
                pol_q    <= pol_c;
                total_q  <= TW'(dim_i) * TW'(dim_j);
                issued_q <= '0;
            end else if (take_wt) begin
                issued_q <= issued_q + TW'(1);
            end
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_x         <= '0;
            out_y         <= '0;
            out_skip      <= 1'b0;
            out_transpose <= 1'b0;
        end else begin
            out_valid <= take_wt;
            if (take_wt) begin
                out_x         <= x_c;
                out_y         <= y_c;
                out_skip      <= skip_c;
                out_transpose <= pol_q.swap;
            end
        end
    end

    assign busy = (state == ST_RUN);
    assign err  = (state == ST_FAULT);

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && (state == ST_RUN)));

    a_r8_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> !out_valid);

    a_r10_policy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && ($past(state) == ST_RUN)) |-> $stable(pol_q));

    a_r4_row_avoid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pol_q.row_red) |-> !row_mask_q[out_x]);

    a_r5_col_avoid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pol_q.col_red) |-> !col_mask_q[out_y]);

    a_r11_no_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_RUN) && !out_valid) |=> !out_valid);

endmodule

// File: tb/test_wm_weight_mapper.sv
`timescale 1ns/1ps
module test_wm_weight_mapper;

    localparam int N     = 4;
    localparam int IDX_W = 4;
    localparam int CW    = $clog2(N + 1);
    localparam int IW    = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [N-1:0]     row_fault = '0;
    logic [N-1:0]     col_fault = '0;
    logic [CW-1:0]    threshold = '0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] dim_i = '0;
    logic [IDX_W-1:0] dim_j = '0;
    logic             in_valid = 1'b0;
    logic [IDX_W-1:0] in_i = '0;
    logic [IDX_W-1:0] in_j = '0;
    logic             busy, err, out_valid, out_skip, out_transpose;
    logic [IW-1:0]    out_x, out_y;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wm_weight_mapper #(.N(N), .IDX_W(IDX_W)) i_wm_weight_mapper (
        .clk(clk), .rst_n(rst_n), .load(load), .row_fault(row_fault),
        .col_fault(col_fault), .threshold(threshold), .start(start),
        .dim_i(dim_i), .dim_j(dim_j), .in_valid(in_valid), .in_i(in_i),
        .in_j(in_j), .busy(busy), .err(err), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y), .out_skip(out_skip),
        .out_transpose(out_transpose)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int popc(input int m);
        int c = 0;
        for (int p = 0; p < N; p++) c += (m >> p) & 1;
        return c;
    endfunction

    function automatic int kth_clear(input int m, input int k);
        int r = 0;
        for (int p = 0; p < N; p++) begin
            if (((m >> p) & 1) == 0) begin
                if (r == k) return p;
                r++;
            end
        end
        return 0;
    endfunction

    // Reference placement computed from R2..R7
    task automatic model(input int rm, input int cm, input int th, input int i, input int j,
                         output int x, output int y, output int sk, output int tr);
        int rc, cc, a, b;
        bit rr, cr;
        rc = popc(rm);
        cc = popc(cm);
        rr = rc > th;
        cr = cc > th;
        tr = (cc != 0 && !rr && !cr) ? 1 : 0;
        a  = tr ? j : i;
        b  = tr ? i : j;
        x  = rr ? kth_clear(rm, a % (N - rc)) : a % N;
        y  = cr ? kth_clear(cm, b % (N - cc)) : b % N;
        sk = (((rm >> x) & 1) | ((cm >> y) & 1));
    endtask

    task automatic do_load(input int rm, input int cm, input int th);
        @(negedge clk);
        row_fault = N'(rm);
        col_fault = N'(cm);
        threshold = CW'(th);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_start(input int di, input int dj);
        @(negedge clk);
        dim_i = IDX_W'(di);
        dim_j = IDX_W'(dj);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Present one weight at a negedge; the result is read one negedge later.
    task automatic send(input int i, input int j);
        in_i = IDX_W'(i);
        in_j = IDX_W'(j);
        in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_check(input int rm, input int cm, input int th, input int i, input int j);
        int x, y, sk, tr;
        bit ok;
        model(rm, cm, th, i, j, x, y, sk, tr);
        send(i, j);
        ok = out_valid && (int'(out_x) == x) && (int'(out_y) == y) &&
             (int'(out_skip) == sk) && (int'(out_transpose) == tr);
        check(ok, "R2/R3/R4/R5/R6/R7/R9 placement",
              {out_valid, out_transpose, out_skip, 8'(out_x), 8'(out_y)},
              {1'b1, 1'(tr), 1'(sk), 8'(x), 8'(y)});
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!out_valid && !busy && !err, "R1 reset outputs", {out_valid, busy, err}, 0);
        // R11: in_valid in IDLE is ignored
        send(1, 1);
        check(!out_valid, "R11 idle weight ignored", out_valid, 0);
        // R1: reset masks are clear, so direct mapping applies
        do_start(2, 2);
        check(busy && !err, "R1 start after reset", {busy, err}, 2);
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++) send_check(0, 0, 0, i + 5, j + 2);
        check(!busy, "R11 run ends", busy, 0);

        // Exhaustive mask sweep
        for (int th = 0; th <= 2; th++) begin
            for (int rm = 0; rm < 16; rm++) begin
                for (int cm = 0; cm < 16; cm++) begin
                    do_load(rm, cm, th);
                    do_start(6, 5);
                    if (rm == 15 || cm == 15) begin
                        check(err && !busy, "R8 all faulty enters error", {err, busy}, 2);
                        send(0, 0);
                        check(!out_valid, "R8 no output in error", out_valid, 0);
                    end else begin
                        check(busy && !err, "R8 usable array runs", {busy, err}, 2);
                        for (int i = 0; i < 6; i++)
                            for (int j = 0; j < 5; j++) send_check(rm, cm, th, i, j);
                        check(!busy, "R11 run ends after dim_i*dim_j", busy, 0);
                    end
                end
            end
        end

        // R8: recovery from FAULT by load
        do_load(15, 0, 0);
        do_start(1, 1);
        check(err, "R8 error set", err, 1);
        do_load(0, 0, 0);
        check(!err && !busy, "R8 load clears error", {err, busy}, 0);

        // R10: load and start during RUN are ignored
        do_load(4'b0010, 0, 0);
        do_start(3, 3);
        send_check(4'b0010, 0, 0, 0, 0);
        do_load(4'b1111, 4'b0101, 2);
        check(busy && !err, "R10 load ignored in run", {busy, err}, 2);
        do_start(1, 1);
        check(busy, "R10 start ignored in run", busy, 1);
        for (int k = 1; k < 9; k++) send_check(4'b0010, 0, 0, k / 3, k % 3);
        check(!busy, "R10 original size kept", busy, 0);
        send(0, 0);
        check(!out_valid, "R11 weight after end ignored", out_valid, 0);
        do_start(2, 1);
        check(busy && !err, "R10 masks unchanged by ignored load", {busy, err}, 2);
        send_check(4'b0010, 0, 0, 1, 0);
        send_check(4'b0010, 0, 0, 5, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule